// File: doc/BRIEF.md
# Clock Register Snapshot and Transfer Controller

This block keeps two copies of an eight-byte timekeeping record. The internal copy follows the free-running counter: whenever the counter signals an increment, the internal copy loads the counter's next value. The user copy is the one the host reads. It is refreshed from the internal copy in one edge, with all eight bytes at once, so a host read never sees a mix of old and new fields. The host reaches a 20-byte register space through a byte pointer. The pointer can be loaded directly, and it steps forward by one after every read or write byte, so bursts are possible. Bytes 08h to 13h are plain storage, except for one bit of byte 0Ch, which is the halt-update flag.

While the host is reading the clock bytes, transfers into the user copy are held back. An increment that arrives during the hold is remembered, and it is applied as soon as the bus signals a stop or the pointer leaves the clock range. A power-fail pulse sets the halt flag. This freezes the user copy at the time of the failure until software writes the flag back to zero. The user copy then catches up with the internal count.

Top module: `rtc_xfer_ctrl`

## Requirements
- R1: After a synchronous reset, the pointer is 00h, both copies and all storage bytes are zero, and the halt flag is clear.
- R2: `addr_load` sets the pointer to `addr_in`, or to 00h when `addr_in` is above 13h. Otherwise each cycle with `rd_en` or `wr_en` advances the pointer by one, and it wraps from 13h to 00h.
- R3: `rd_data` shows, combinationally, the byte at the pointer. Addresses 00h–07h (byte i at address i) come from the user copy. Addresses 08h–13h come from storage, except that bit 6 of address 0Ch reads the halt flag.
- R4: When `inc_pulse` arrives with no hold and the halt flag clear, the internal copy and the user copy both take `cnt_next` at the same edge. Byte i is `cnt_next[8i+7:8i]`.
- R5: A transfer is suppressed in any cycle where the pointer is in 00h–07h and either `rd_en` is high or a read session is open and `bus_stop` is low. A session opens with `rd_en` and closes with `bus_stop`.
- R6: An increment that is not transferred sets a pending flag. The first cycle that has neither a hold nor the halt flag then copies the internal copy into the user copy and clears the pending flag.
- R7: `pwr_fail` sets the halt flag, which blocks all transfers. A write to 0Ch loads the flag from data bit 6. `pwr_fail` wins over a write in the same cycle.
- R8: A write to a clock address stores the byte into both copies at that edge, overriding any increment or transfer for that byte. Byte 00h of both copies is forced to 00h on every clock-address write.
- R9: `int_time` always presents the internal copy, with byte i at bits `8i+7:8i`.
- R10: A write to 08h–13h changes only that storage byte and leaves both copies untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Load the pointer from `addr_in` |
| addr_in | input | 5 | New pointer value |
| rd_en | input | 1 | Host reads the byte at the pointer this cycle |
| wr_en | input | 1 | Host writes `wr_data` at the pointer this cycle |
| wr_data | input | 8 | Write byte |
| bus_stop | input | 1 | Bus stop event; closes the read session |
| rd_data | output | 8 | Byte at the current pointer |
| inc_pulse | input | 1 | Counter has advanced this cycle |
| cnt_next | input | 64 | Counter value to load on `inc_pulse` |
| int_time | output | 64 | Internal copy |
| pwr_fail | input | 1 | Power-fail event |

## Verification
Every state change lands on the clock edge that samples its stimulus. `rd_data` is combinational on the pointer, so the result of a load, write or transfer can be read in the cycle after the stimulus, with no added latency. A pending transfer lands one edge after its release: after the edge that moves the pointer out of the clock range, or on the edge of the `bus_stop` cycle itself. The bench drives inputs at the falling edge and updates its model at the rising edge. It compares `rd_data` and `int_time` against the model at every falling edge, and also checks literal expected values after each directed sequence.

// File: rtl/rtc_xfer_pkg.sv
package rtc_xfer_pkg;

    localparam int RTC_NREG    = 20;
    localparam int RTC_NCLK    = 8;
    localparam int RTC_DW      = 8;
    localparam int RTC_HT_ADDR = 12;
    localparam int RTC_HT_BIT  = 6;

    // Step a register index forward, wrapping at the end of the map.
    function automatic int wrap_inc(int a, int n);
        return (a >= n - 1) ? 0 : a + 1;
    endfunction

    // Clamp an out-of-map address to zero.
    function automatic int clamp_addr(int a, int n);
        return (a < n) ? a : 0;
    endfunction

    // Control bits passed from the hold logic to the register bank.
    typedef struct packed {
        logic xfer;
        logic ht;
    } xfer_ctl_t;

endpackage

// File: rtl/rtc_addr_ptr.sv
module rtc_addr_ptr
    import rtc_xfer_pkg::*;
#(
    parameter int NREG = RTC_NREG,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    output logic [AW-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (load)
            ptr <= AW'(clamp_addr(int'(load_val), NREG));
        else if (adv)
            ptr <= AW'(wrap_inc(int'(ptr), NREG));
    end

    // R2: pointer never leaves the map
    a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) < NREG);

    // R2: last address wraps to zero on a sequential step
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (int'(ptr) == NREG - 1 && adv && !load) |=> (ptr == '0));

endmodule

// File: rtl/rtc_hold_ctrl.sv
module rtc_hold_ctrl
    import rtc_xfer_pkg::*;
#(
    parameter int NCLK = RTC_NCLK,
    parameter int AW   = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ptr,
    input  logic          rd_en,
    input  logic          bus_stop,
    input  logic          inc_pulse,
    input  logic          pwr_fail,
    input  logic          ht_wr,
    input  logic          ht_wdata,
    output xfer_ctl_t     ctl
);

    logic sess_q;
    logic pend_q;
    logic ht_q;
    logic ptr_clk;
    logic hold;
    logic xfer;

    assign ptr_clk = int'(ptr) < NCLK;
    assign hold    = ptr_clk && (rd_en || (sess_q && !bus_stop));
    assign xfer    = (inc_pulse || pend_q) && !hold && !ht_q;

    assign ctl.xfer = xfer;
    assign ctl.ht   = ht_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sess_q <= 1'b0;
            pend_q <= 1'b0;
            ht_q   <= 1'b0;
        end else begin
            if (bus_stop)
                sess_q <= 1'b0;
            else if (rd_en)
                sess_q <= 1'b1;

            if (xfer)
                pend_q <= 1'b0;
            else if (inc_pulse)
                pend_q <= 1'b1;

            if (pwr_fail)
                ht_q <= 1'b1;
            else if (ht_wr)
                ht_q <= ht_wdata;
        end
    end

    // R7: power failure always raises the halt flag
    a_r7_ht_set: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> ht_q);

    // R6: an increment that was not transferred is remembered
    a_r6_pend_set: assert property (@(posedge clk) disable iff (rst)
        (inc_pulse && !xfer) |=> pend_q);

    // R5: a read session closes on a stop event
    a_r5_sess_close: assert property (@(posedge clk) disable iff (rst)
        bus_stop |=> !sess_q);

endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank
    import rtc_xfer_pkg::*;
#(
    parameter int NREG    = RTC_NREG,
    parameter int NCLK    = RTC_NCLK,
    parameter int DW      = RTC_DW,
    parameter int HT_ADDR = RTC_HT_ADDR,
    parameter int HT_BIT  = RTC_HT_BIT,
    parameter int AW      = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [AW-1:0]      ptr,
    input  logic               wr_en,
    input  logic [DW-1:0]      wr_data,
    input  logic               inc_pulse,
    input  logic [NCLK*DW-1:0] cnt_next,
    input  xfer_ctl_t          ctl,
    output logic [NCLK*DW-1:0] int_time,
    output logic [DW-1:0]      rd_data
);

    localparam int NST = NREG - NCLK;

    logic [NCLK-1:0][DW-1:0] user_q, user_n;
    logic [NCLK-1:0][DW-1:0] int_q, int_n;
    logic [NST-1:0][DW-1:0]  st_q;
    logic                    wr_clk;

    assign wr_clk = wr_en && (int'(ptr) < NCLK);

    always_comb begin
        for (int i = 0; i < NCLK; i++) begin
            int_n[i]  = inc_pulse ? cnt_next[i*DW +: DW] : int_q[i];
            user_n[i] = ctl.xfer ? int_n[i] : user_q[i];
            if (wr_clk && ptr == AW'(i)) begin
                int_n[i]  = wr_data;
                user_n[i] = wr_data;
            end
        end
        if (wr_clk) begin
            int_n[0]  = '0;
            user_n[0] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            user_q <= '0;
            int_q  <= '0;
            st_q   <= '0;
        end else begin
            user_q <= user_n;
            int_q  <= int_n;
            for (int j = 0; j < NST; j++)
                if (wr_en && ptr == AW'(NCLK + j))
                    st_q[j] <= wr_data;
        end
    end

    assign int_time = int_q;

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCLK; i++)
            if (ptr == AW'(i))
                rd_data = user_q[i];
        for (int j = 0; j < NST; j++)
            if (ptr == AW'(NCLK + j)) begin
                rd_data = st_q[j];
                if (NCLK + j == HT_ADDR)
                    rd_data[HT_BIT] = ctl.ht;
            end
    end

    // R4: after a transfer both copies agree
    a_r4_copies_match: assert property (@(posedge clk) disable iff (rst)
        ctl.xfer |=> (user_q == int_q));

    // R8: a clock write leaves the sub-second byte at zero in both copies
    a_r8_sub_clear: assert property (@(posedge clk) disable iff (rst)
        wr_clk |=> (user_q[0] == '0 && int_q[0] == '0));

    // R5: without a transfer or clock write the user copy holds
    a_r5_user_frozen: assert property (@(posedge clk) disable iff (rst)
        (!ctl.xfer && !wr_clk) |=> $stable(user_q));

endmodule

// File: rtl/rtc_xfer_ctrl.sv
module rtc_xfer_ctrl
    import rtc_xfer_pkg::*;
#(
    parameter int NREG    = RTC_NREG,
    parameter int NCLK    = RTC_NCLK,
    parameter int DW      = RTC_DW,
    parameter int HT_ADDR = RTC_HT_ADDR,
    parameter int HT_BIT  = RTC_HT_BIT,
    localparam int AW     = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               addr_load,
    input  logic [AW-1:0]      addr_in,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [DW-1:0]      wr_data,
    input  logic               bus_stop,
    output logic [DW-1:0]      rd_data,
    input  logic               inc_pulse,
    input  logic [NCLK*DW-1:0] cnt_next,
    output logic [NCLK*DW-1:0] int_time,
    input  logic               pwr_fail
);

    logic [AW-1:0] ptr;
    logic          ht_wr;
    xfer_ctl_t     ctl;

    assign ht_wr = wr_en && (ptr == AW'(HT_ADDR));

    rtc_addr_ptr #(.NREG(NREG), .AW(AW)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (addr_load),
        .load_val (addr_in),
        .adv      (rd_en || wr_en),
        .ptr      (ptr)
    );

    rtc_hold_ctrl #(.NCLK(NCLK), .AW(AW)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .ptr       (ptr),
        .rd_en     (rd_en),
        .bus_stop  (bus_stop),
        .inc_pulse (inc_pulse),
        .pwr_fail  (pwr_fail),
        .ht_wr     (ht_wr),
        .ht_wdata  (wr_data[HT_BIT]),
        .ctl       (ctl)
    );

    rtc_reg_bank #(
        .NREG(NREG), .NCLK(NCLK), .DW(DW),
        .HT_ADDR(HT_ADDR), .HT_BIT(HT_BIT), .AW(AW)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .inc_pulse (inc_pulse),
        .cnt_next  (cnt_next),
        .ctl       (ctl),
        .int_time  (int_time),
        .rd_data   (rd_data)
    );

    // R7: halt flag blocks every transfer
    a_r7_ht_blocks: assert property (@(posedge clk) disable iff (rst)
        ctl.ht |-> !ctl.xfer);

endmodule

// File: tb/tb_rtc_xfer_ctrl.sv
module tb_rtc_xfer_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_load = 1'b0;
    logic [4:0]  addr_in = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        bus_stop = 1'b0;
    logic [7:0]  rd_data;
    logic        inc_pulse = 1'b0;
    logic [63:0] cnt_next = '0;
    logic [63:0] int_time;
    logic        pwr_fail = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rtc_xfer_ctrl dut (
        .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .bus_stop(bus_stop),
        .rd_data(rd_data), .inc_pulse(inc_pulse), .cnt_next(cnt_next),
        .int_time(int_time), .pwr_fail(pwr_fail)
    );

    // Behavioural reference model
    logic [7:0] m_user [8];
    logic [7:0] m_int  [8];
    logic [7:0] m_st   [20];
    int         m_ptr;
    bit         m_sess, m_pend, m_ht;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_user[i]) begin m_user[i] = '0; m_int[i] = '0; end
            foreach (m_st[i]) m_st[i] = '0;
            m_ptr = 0; m_sess = 0; m_pend = 0; m_ht = 0;
        end else begin
            bit held, go;
            logic [7:0] ni [8];
            logic [7:0] nu [8];
            held = (m_ptr < 8) && (rd_en || (m_sess && !bus_stop));
            go   = (inc_pulse || m_pend) && !held && !m_ht;
            for (int i = 0; i < 8; i++) begin
                ni[i] = inc_pulse ? cnt_next[i*8 +: 8] : m_int[i];
                nu[i] = go ? ni[i] : m_user[i];
            end
            if (wr_en && m_ptr < 8) begin
                ni[m_ptr] = wr_data; nu[m_ptr] = wr_data;
                ni[0] = '0; nu[0] = '0;
            end
            if (wr_en && m_ptr >= 8) m_st[m_ptr] = wr_data;
            if (pwr_fail) m_ht = 1;
            else if (wr_en && m_ptr == 12) m_ht = wr_data[6];
            if (go) m_pend = 0; else if (inc_pulse) m_pend = 1;
            if (bus_stop) m_sess = 0; else if (rd_en) m_sess = 1;
            if (addr_load) m_ptr = (addr_in < 20) ? int'(addr_in) : 0;
            else if (rd_en || wr_en) m_ptr = (m_ptr == 19) ? 0 : m_ptr + 1;
            for (int i = 0; i < 8; i++) begin m_int[i] = ni[i]; m_user[i] = nu[i]; end
        end
    end

    function automatic logic [7:0] m_rd();
        logic [7:0] v;
        if (m_ptr < 8) return m_user[m_ptr];
        v = m_st[m_ptr];
        if (m_ptr == 12) v[6] = m_ht;
        return v;
    endfunction

    function automatic logic [63:0] m_time();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = m_int[i];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3 model rd_data", 64'(rd_data), 64'(m_rd()));
            chk("R9 model int_time", int_time, m_time());
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        addr_load = 0; rd_en = 0; wr_en = 0; bus_stop = 0;
        inc_pulse = 0; pwr_fail = 0;
    endtask

    task automatic ld(input logic [4:0] a);
        addr_load = 1; addr_in = a; step(); idle();
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1; wr_data = d; step(); idle();
    endtask

    task automatic rd(input string tag, input logic [7:0] e);
        chk(tag, 64'(rd_data), 64'(e));
        rd_en = 1; step(); idle();
    endtask

    task automatic stop();
        bus_stop = 1; step(); idle();
    endtask

    task automatic tick(input logic [63:0] v);
        inc_pulse = 1; cnt_next = v; step(); idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        step();
        // R1 reset state
        chk("R1 rd_data after reset", 64'(rd_data), 64'h0);
        chk("R1 int_time after reset", int_time, 64'h0);

        // R8 burst write of the clock bytes; byte 0 is forced to 00
        ld(0);
        wr(8'h55); wr(8'h30); wr(8'h45); wr(8'h12);
        wr(8'h04); wr(8'h21); wr(8'h06); wr(8'h24);
        chk("R8 burst write int_time", int_time, 64'h2406_2104_1245_3000);
        ld(0);
        rd("R8 subsecond forced 00", 8'h00);
        rd("R3 read byte 1", 8'h30);
        stop();

        // R4 plain transfer
        tick(64'h2406_2104_1245_3101);
        ld(1);
        chk("R4 transfer seen by host", 64'(rd_data), 64'h31);
        chk("R9 int_time follows count", int_time, 64'h2406_2104_1245_3101);

        // R5 hold during a clock read, R6 release by leaving the range
        ld(0);
        rd("R3 read byte 0", 8'h01);
        tick(64'h2406_2104_1245_3202);
        chk("R5 user copy held", 64'(rd_data), 64'h31);
        chk("R9 internal advanced while held", int_time, 64'h2406_2104_1245_3202);
        rd("R5 user copy held on next byte", 8'h31);
        ld(8);
        step();
        ld(1);
        chk("R6 pending applied after leaving range", 64'(rd_data), 64'h32);
        stop();

        // R6 release by a stop event
        ld(2);
        rd("R3 read byte 2", 8'h45);
        tick(64'h2406_2104_1246_3303);
        step();
        stop();
        ld(2);
        chk("R6 pending applied on stop", 64'(rd_data), 64'h46);

        // R7 power failure halts transfers
        pwr_fail = 1; step(); idle();
        ld(12);
        chk("R7 halt flag reads as bit 6", 64'(rd_data), 64'h40);
        tick(64'h2406_2104_1247_3404);
        ld(2);
        chk("R7 user copy frozen", 64'(rd_data), 64'h46);
        ld(12);
        wr(8'h00);
        step();
        ld(2);
        chk("R7 catch-up after clearing halt", 64'(rd_data), 64'h47);
        ld(12);
        pwr_fail = 1; wr_en = 1; wr_data = 8'h00; step(); idle();
        ld(12);
        chk("R7 power fail beats write", 64'(rd_data), 64'h40);
        wr(8'h00);

        // R2 wrap and clamp, R10 storage write
        ld(19);
        wr(8'hA5);
        chk("R2 wrap to 00", 64'(rd_data), 64'h04);
        chk("R10 copies untouched by storage write", int_time, 64'h2406_2104_1247_3404);
        ld(19);
        chk("R10 storage byte stored", 64'(rd_data), 64'hA5);
        ld(25);
        chk("R2 out-of-map load clamps to 00", 64'(rd_data), 64'h04);

        // R8 write beats a simultaneous increment on its byte
        ld(3);
        inc_pulse = 1; cnt_next = 64'h2406_2104_1348_3505;
        wr_en = 1; wr_data = 8'h09; step(); idle();
        chk("R8 write priority int_time", int_time, 64'h2406_2104_0948_3500);
        ld(3);
        chk("R8 written byte in user copy", 64'(rd_data), 64'h09);
        ld(2);
        chk("R8 other bytes transferred", 64'(rd_data), 64'h48);

        step();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule